// File: doc/BRIEF.md
# Card-Host Transmit Word Buffer

This block is the outbound word buffer of a memory-card host controller. A processor or DMA engine pushes 32-bit words into it. A serial data-path shifter pulls them out one at a time. The oldest stored word is always held in an output register. The shifter pulses an acknowledge when it has copied that word into its shift register. The buffer then drops the word, and the next one appears in the output register on the following clock edge.

Alongside the data the block reports four occupancy flags: full, empty, half-empty and data-available. The half-empty flag is meant to be wired straight to a DMA request line. The block also keeps a sticky underrun flag. Underrun is raised when the shifter asks for a word during an active transmission while nothing is stored, and only a one-cycle clear strobe removes it. An enable input gates the whole buffer. While enable is low, every flag reads zero and both pointers and the occupancy count are held at zero, so switching the buffer off discards its contents.

Top module: `card_tx_fifo`

## Requirements
- R1: After reset, with enable high, empty=1, data_avail=0, half_empty=1, full=0 and underrun=0.
- R2: Each accepted write stores wr_data at the write pointer and advances that pointer, so words leave the buffer in the order they were written.
- R3: While the buffer holds data, out_word shows the oldest stored word. A cycle with ld_ack high removes that word, and out_word shows the next word after the same clock edge.
- R4: full is high only when all DEPTH (16) entries hold data. A write while full is dropped and leaves the stored words and their order unchanged.
- R5: half_empty, the DMA request, is high exactly when at least DEPTH/2 (8) entries are free, that is when the occupancy is 8 or less.
- R6: While enable is high, data_avail is always the inverse of empty.
- R7: A cycle with ld_ack=1, tx_active=1 and an empty buffer sets underrun. Once set, underrun stays set until it is cleared.
- R8: A one-cycle clr_err pulse clears underrun on the next edge. If a new underrun occurs in the same cycle as the clear, the flag stays set.
- R9: While enable is low, all five flags read 0, the pointers and the count are held at 0, and writes are ignored. After enable returns high, the buffer is empty.
- R10: A cycle that has both an accepted write and an accepted removal performs both, and the occupancy is unchanged. On a full buffer the write in such a cycle is dropped.
- R11: ld_ack on an empty buffer with tx_active low changes nothing and does not set underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Buffer enable; low clears pointers, count and flags |
| wr_en | input | 1 | Bus-side write strobe |
| wr_data | input | 32 | Word to store |
| ld_ack | input | 1 | Shifter has loaded out_word |
| tx_active | input | 1 | Data path is transmitting |
| clr_err | input | 1 | One-cycle clear strobe for underrun |
| out_word | output | 32 | Registered oldest word |
| full | output | 1 | All entries hold data |
| empty | output | 1 | No entry holds data |
| half_empty | output | 1 | At least half the entries are free (DMA request) |
| data_avail | output | 1 | At least one entry holds data |
| underrun | output | 1 | Sticky underrun error |

## Verification
Two pairs of events can land in the same cycle: a bus write with a shifter removal, and an underrun event with the clear strobe. The bench raises wr_en and ld_ack together on a partly filled buffer and on a full one. It judges the result from the flags and from the order of words seen on out_word, using a queue model. It also pulses clr_err in the same cycle as an empty-buffer request during transmission and expects underrun to remain set.

// File: rtl/card_tx_fifo_pkg.sv
package card_tx_fifo_pkg;
    typedef struct packed {
        logic full;
        logic empty;
        logic half_empty;
        logic data_avail;
    } occ_flags_t;

    localparam occ_flags_t FLAGS_OFF = '{full: 1'b0, empty: 1'b0, half_empty: 1'b0, data_avail: 1'b0};
endpackage

// File: rtl/tx_word_store.sv
module tx_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == PW'(i)) cell_q[i] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/tx_occ_ctrl.sv
module tx_occ_ctrl
    import card_tx_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              push,
    output logic [PW-1:0]     wr_ptr,
    output logic [PW-1:0]     rd_next,
    output logic              is_empty,
    output logic [DATA_W-1:0] out_word,
    output occ_flags_t        flags
);
    typedef struct packed {
        logic [PW-1:0]     wr_ptr;
        logic [PW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic [DATA_W-1:0] out_word;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    logic        pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push    = enable && wr_req && (s_q.count != CW'(DEPTH));
        pop     = enable && rd_ack && (s_q.count != '0);
        rd_next = pop ? ptr_inc(s_q.rd_ptr) : s_q.rd_ptr;
        if (!enable) begin
            s_d = '0;
        end else begin
            s_d.rd_ptr = rd_next;
            if (push) s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
            case ({push, pop})
                2'b10:   s_d.count = s_q.count + 1'b1;
                2'b01:   s_d.count = s_q.count - 1'b1;
                default: s_d.count = s_q.count;
            endcase
            // output register mirrors the cell at the next read pointer,
            // bypassing a word written into that same cell this cycle
            s_d.out_word = (push && s_q.wr_ptr == rd_next) ? wr_data : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ptr   = s_q.wr_ptr;
    assign is_empty = (s_q.count == '0);
    assign out_word = s_q.out_word;

    always_comb begin
        flags = FLAGS_OFF;
        if (enable) begin
            flags.full       = (s_q.count == CW'(DEPTH));
            flags.empty      = (s_q.count == '0);
            flags.half_empty = (s_q.count <= CW'(DEPTH - HALF));
            flags.data_avail = (s_q.count != '0);
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && s_q.count == CW'(DEPTH) && wr_req && !rd_ack) |=> (s_q.count == CW'(DEPTH) && $stable(s_q.wr_ptr)));

    assert_push_pop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_req && rd_ack && s_q.count != '0 && s_q.count != CW'(DEPTH)) |=> (s_q.count == $past(s_q.count)));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (s_q.count == '0 && s_q.wr_ptr == '0 && s_q.rd_ptr == '0));
endmodule

// File: rtl/tx_underrun_flag.sv
module tx_underrun_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rd_ack,
    input  logic tx_active,
    input  logic is_empty,
    input  logic clr_err,
    output logic underrun
);
    typedef struct packed {
        logic err;
    } err_state_t;

    err_state_t e_d, e_q;
    logic       hit;

    always_comb begin
        e_d = e_q;
        hit = rd_ack && tx_active && is_empty;
        if (!enable)      e_d.err = 1'b0;
        else if (hit)     e_d.err = 1'b1;
        else if (clr_err) e_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign underrun = e_q.err;

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.err && enable && !clr_err) |=> e_q.err);

    assert_underrun_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_ack && tx_active && is_empty) |=> e_q.err);

    assert_underrun_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !(rd_ack && tx_active && is_empty)) |=> !e_q.err);

    assert_idle_request_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_q.err && !tx_active) |=> !e_q.err);
endmodule

// File: rtl/card_tx_fifo.sv
module card_tx_fifo
    import card_tx_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_ack,
    input  logic              tx_active,
    input  logic              clr_err,
    output logic [DATA_W-1:0] out_word,
    output logic              full,
    output logic              empty,
    output logic              half_empty,
    output logic              data_avail,
    output logic              underrun
);
    logic              push;
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_next;
    logic [DATA_W-1:0] rd_data;
    logic              is_empty;
    occ_flags_t        flags;
    logic              err_raw;

    tx_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_next),
        .rdata (rd_data)
    );

    tx_occ_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .wr_req   (wr_en),
        .wr_data  (wr_data),
        .rd_ack   (ld_ack),
        .rd_data  (rd_data),
        .push     (push),
        .wr_ptr   (wr_ptr),
        .rd_next  (rd_next),
        .is_empty (is_empty),
        .out_word (out_word),
        .flags    (flags)
    );

    tx_underrun_flag u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rd_ack    (ld_ack),
        .tx_active (tx_active),
        .is_empty  (is_empty),
        .clr_err   (clr_err),
        .underrun  (err_raw)
    );

    assign full       = flags.full;
    assign empty      = flags.empty;
    assign half_empty = flags.half_empty;
    assign data_avail = flags.data_avail;
    assign underrun   = err_raw;

    always_comb begin
        if (rst_n && enable) assert_avail_inverse_R6: assert (data_avail == !empty);
        if (rst_n && !enable) assert_flags_low_off_R9: assert (!(full || empty || half_empty || data_avail));
    end
endmodule

// File: tb/card_tx_fifo_bench.sv
module card_tx_fifo_bench;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0, wr_en = 1'b0, ld_ack = 1'b0, tx_active = 1'b0, clr_err = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] out_word;
    logic          full, empty, half_empty, data_avail, underrun;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mq[$];
    logic          m_err = 1'b0;

    always #5 clk = ~clk;

    card_tx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_card_tx_fifo (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
        .ld_ack(ld_ack), .tx_active(tx_active), .clr_err(clr_err), .out_word(out_word),
        .full(full), .empty(empty), .half_empty(half_empty), .data_avail(data_avail),
        .underrun(underrun)
    );

    // one clock: drive at negedge, update model, sample 1 ns after the edge
    task automatic step(input logic w, input logic [DW-1:0] d, input logic a,
                        input logic act, input logic clr);
        logic do_push, do_pop, hit;
        @(negedge clk);
        wr_en = w; wr_data = d; ld_ack = a; tx_active = act; clr_err = clr;
        do_push = enable && w && (mq.size() < DEPTH);
        do_pop  = enable && a && (mq.size() > 0);
        hit     = enable && a && act && (mq.size() == 0);
        @(posedge clk);
        #1;
        if (!enable) begin
            mq.delete();
            m_err = 1'b0;
        end else begin
            if (do_pop) void'(mq.pop_front());
            if (do_push) mq.push_back(d);
            if (hit) m_err = 1'b1;
            else if (clr) m_err = 1'b0;
        end
        wr_en = 1'b0; ld_ack = 1'b0; clr_err = 1'b0;
    endtask

    task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int n;
        n = mq.size();
        checks++;
        cmp(tag, "full",       DW'(full),       DW'(enable && n == DEPTH));
        cmp(tag, "empty",      DW'(empty),      DW'(enable && n == 0));
        cmp(tag, "half_empty", DW'(half_empty), DW'(enable && (DEPTH - n) >= DEPTH / 2));
        cmp(tag, "data_avail", DW'(data_avail), DW'(enable && n != 0));
        cmp(tag, "underrun",   DW'(underrun),   DW'(m_err));
        if (enable && n > 0) cmp(tag, "out_word", out_word, mq[0]);
    endtask

    task automatic t_reset_R1;
        enable = 1'b1;
        step(0, '0, 0, 0, 0);
        check_all("R1");
    endtask

    task automatic t_order_R2_R3;
        for (int i = 0; i < 5; i++) begin
            step(1, 32'hA000_0000 + DW'(i), 0, 1, 0);
            check_all("R2");
        end
        for (int i = 0; i < 5; i++) begin
            step(0, '0, 1, 1, 0);
            check_all("R3");
        end
    endtask

    task automatic t_full_R4_R5;
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 32'hF00D_0000 + DW'(i * 7), 0, 0, 0);
            check_all((i == 7 || i == 8) ? "R5" : "R4");
        end
        step(1, 32'hDEAD_BEEF, 0, 0, 0);
        check_all("R4");
        for (int i = 0; i < DEPTH; i++) begin
            step(0, '0, 1, 1, 0);
            check_all((i == 7 || i == 8) ? "R5" : "R4");
        end
    endtask

    task automatic t_underrun_R7_R8_R11;
        step(0, '0, 1, 0, 0);
        check_all("R11");
        step(0, '0, 1, 1, 0);
        check_all("R7");
        step(0, '0, 0, 0, 0);
        step(1, 32'h1234_5678, 0, 0, 0);
        check_all("R7");
        step(0, '0, 1, 0, 0);
        step(0, '0, 0, 0, 1);
        check_all("R8");
        step(0, '0, 1, 1, 1);
        check_all("R8");
        step(0, '0, 0, 0, 1);
        check_all("R8");
    endtask

    task automatic t_disable_R9;
        for (int i = 0; i < 3; i++) step(1, 32'h5555_0000 + DW'(i), 0, 0, 0);
        step(0, '0, 0, 0, 0);
        // raise underrun via full-drain then empty request
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 0);
        step(0, '0, 1, 1, 0);
        check_all("R7");
        for (int i = 0; i < 2; i++) step(1, 32'h6666_0000 + DW'(i), 0, 0, 0);
        @(negedge clk);
        enable = 1'b0;
        step(1, 32'h7777_7777, 0, 0, 0);
        check_all("R9");
        step(1, 32'h7777_7778, 1, 1, 0);
        check_all("R9");
        @(negedge clk);
        enable = 1'b1;
        #1;
        check_all("R9");
        step(1, 32'hC0FF_EE00, 0, 0, 0);
        check_all("R9");
        step(0, '0, 1, 0, 0);
        check_all("R9");
    endtask

    task automatic t_simul_R10;
        for (int i = 0; i < 4; i++) step(1, 32'hB000_0000 + DW'(i), 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            step(1, 32'hB100_0000 + DW'(i), 1, 0, 0);
            check_all("R10");
        end
        for (int i = 0; i < DEPTH; i++) step(1, 32'hB200_0000 + DW'(i), 0, 0, 0);
        check_all("R10");
        step(1, 32'hBAD0_0000, 1, 0, 0);
        check_all("R10");
        while (mq.size() > 0) begin
            step(0, '0, 1, 0, 0);
            check_all("R10");
        end
        step(1, 32'hB300_0001, 1, 0, 0);
        check_all("R10");
        step(0, '0, 1, 0, 0);
        check_all("R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        cmp("R1", "underrun in reset", DW'(underrun), '0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_R1();
        t_order_R2_R3();
        t_full_R4_R5();
        t_underrun_R7_R8_R11();
        t_disable_R9();
        t_simul_R10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule